// File: doc/BRIEF.md
# Guarded Byte-Order Word Store Unit

This unit takes word stores from a processor's store issue port and turns them into writes for a byte-addressable data memory. Each request carries a guard value, a byte address and a data word. Bit 0 of the guard decides whether the store happens at all. When it is clear, the request leaves no trace: no write is issued and no status changes. Accepted stores come out one cycle later as a single-cycle write strobe. The strobe carries a word address, all byte enables set and the data bytes placed into lanes according to a global byte-order control. The lane arrangement comes from XOR-ing each byte's offset with a swap constant.

Stores whose address falls inside an inclusive I/O window, given by base and limit inputs, go to a separate I/O write port instead. That port carries the data word exactly as received, whatever the byte-order setting. A guarded store to an address that is not word aligned still writes, to the word that holds it. It also sets a sticky misalignment flag, which only an explicit clear input or reset removes. If misalignment trapping is enabled at that moment, a trap request is raised and held until the interruptible-jump acknowledge takes it.

Top module: `wstore_unit`

## Requirements
- R1: While reset is asserted, and after it, before any accepted store, every output is zero: both write strobes low, addresses, data and byte enables zero, the flag and the trap request low.
- R2: A request with `req_valid`=1 and `req_guard` bit 0 = 1, to an address outside the I/O window, produces `mem_we`=1 in the following cycle and for that cycle only, with `mem_waddr` = address bits 31:2 and `mem_be` = 4'b1111.
- R3: With `little_en`=0 (big-endian), the byte at offset k of the word, which is `mem_wdata` bits 8k+7:8k, holds data byte 3-k. So 0x44332211 is written as `mem_wdata` = 0x11223344, putting 0x44 at offset 0.
- R4: With `little_en`=1 (little-endian), `mem_wdata` equals the request data unchanged.
- R5: A request with `req_guard` bit 0 = 0 is ignored, whatever the upper guard bits, the address and the other controls. Neither write port strobes, and neither `misalign_flag` nor `trap_pending` changes.
- R6: A guarded store whose address bits 1:0 are not 00 is still written at the truncated word address with all byte enables set. It also sets `misalign_flag` in the following cycle.
- R7: `misalign_flag` stays set until a cycle with `status_clr`=1, after which it reads 0. If a misaligned store is accepted in that same cycle, the flag stays 1.
- R8: A guarded misaligned store while `trap_en`=1 sets `trap_pending` in the following cycle. With `trap_en`=0 the trap request is unchanged.
- R9: `trap_pending` stays set until a cycle with `jump_ack`=1, after which it reads 0. A new trapping store in that same cycle keeps it at 1.
- R10: A guarded store with `io_base` <= address <= `io_limit` drives `io_we`=1 in the following cycle, with `io_waddr` = address bits 31:2 and `io_wdata` = the request data unmodified for either byte order. `mem_we` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Store request present |
| req_guard | input | 32 | Guard value; only bit 0 is used |
| req_addr | input | 32 | Byte address of the store |
| req_data | input | 32 | Word to store |
| little_en | input | 1 | Byte order: 1 little-endian, 0 big-endian |
| trap_en | input | 1 | Raise a trap request on misaligned stores |
| status_clr | input | 1 | Clears the misalignment flag |
| jump_ack | input | 1 | Interruptible jump taking the pending trap |
| io_base | input | 32 | Lowest byte address of the I/O window |
| io_limit | input | 32 | Highest byte address of the I/O window |
| mem_we | output | 1 | Memory write strobe, one cycle per store |
| mem_waddr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Lane-arranged write data |
| mem_be | output | 4 | Memory byte enables |
| io_we | output | 1 | I/O write strobe |
| io_waddr | output | 30 | I/O word address |
| io_wdata | output | 32 | Unswapped I/O write data |
| misalign_flag | output | 1 | Sticky misaligned-store status |
| trap_pending | output | 1 | Pending misaligned-store trap request |

## Verification
The assertions assume that every input is a known value at each rising clock edge once reset is released, and that `io_base` does not exceed `io_limit`. The window check also assumes that the window bounds do not move between a request and its write. The stimulus sets the window once, before reset is released, with base below limit, and leaves it fixed. It drives every input at falling edges only, to defined values, both in the directed cases and in the seeded random phase. The random phase mixes guard values, aligned and misaligned addresses, window hits and misses, and the clear and acknowledge inputs.

// File: rtl/wstore_pkg.sv
package wstore_pkg;

   typedef enum logic {
      ORDER_BIG    = 1'b0,
      ORDER_LITTLE = 1'b1
   } byte_order_e;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/wstore_lane_mux.sv
module wstore_lane_mux #(
   parameter int DATA_W = 32,
   localparam int LANES  = DATA_W / 8,
   localparam int OFFS_W = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] word_in,
   input  wstore_pkg::byte_order_e order,
   output logic [DATA_W-1:0] word_out
);

   logic [OFFS_W-1:0] swap_k;
   assign swap_k = (order == wstore_pkg::ORDER_LITTLE) ? {OFFS_W{1'b1}} : {OFFS_W{1'b0}};

   // Lane k takes the byte whose index i satisfies k == (LANES-1-i) ^ swap_k.
   for (genvar gk = 0; gk < LANES; gk++) begin : g_lane
      localparam logic [OFFS_W-1:0] LANE_K = OFFS_W'(gk);
      logic [OFFS_W-1:0] src_i;
      assign src_i = ~(LANE_K ^ swap_k);
      assign word_out[8*gk +: 8] = word_in[{src_i, 3'b000} +: 8];
   end

endmodule

// File: rtl/wstore_window.sv
module wstore_window #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   output logic              hit
);

   assign hit = (addr >= lo) && (addr <= hi);

endmodule

// File: rtl/wstore_status.sv
module wstore_status (
   input  logic clk,
   input  logic rst_n,
   input  logic mis_set,
   input  logic trap_en,
   input  logic flag_clr,
   input  logic take_ack,
   output logic flag_q,
   output logic trap_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         trap_q <= 1'b0;
      end else begin
         if (mis_set)       flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
         if (mis_set && trap_en) trap_q <= 1'b1;
         else if (take_ack)      trap_q <= 1'b0;
      end
   end

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      mis_set |=> flag_q); // R6
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr) |=> flag_q); // R7
   AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!mis_set && !flag_clr) |=> $stable(flag_q)); // R5
   AST_TRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (mis_set && trap_en) |=> trap_q); // R8
   AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_q && !take_ack) |=> trap_q); // R9
   AST_TRAP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_q && !(mis_set && trap_en)) |=> !trap_q); // R8

endmodule

// File: rtl/wstore_unit.sv
module wstore_unit #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int GUARD_W = 32,
   localparam int LANES  = DATA_W / 8,
   localparam int OFFS_W = $clog2(LANES),
   localparam int WADR_W = ADDR_W - OFFS_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [GUARD_W-1:0] req_guard,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_data,
   input  logic               little_en,
   input  logic               trap_en,
   input  logic               status_clr,
   input  logic               jump_ack,
   input  logic [ADDR_W-1:0]  io_base,
   input  logic [ADDR_W-1:0]  io_limit,
   output logic               mem_we,
   output logic [WADR_W-1:0]  mem_waddr,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic [LANES-1:0]   mem_be,
   output logic               io_we,
   output logic [WADR_W-1:0]  io_waddr,
   output logic [DATA_W-1:0]  io_wdata,
   output logic               misalign_flag,
   output logic               trap_pending
);

   initial begin : chk_params
      if (DATA_W % 8 != 0) $error("DATA_W must be a whole number of bytes");
      if (!wstore_pkg::is_pow2(LANES) || LANES < 2) $error("byte lanes must be a power of two, at least 2");
      if (ADDR_W <= OFFS_W) $error("ADDR_W too small for the lane offset");
      if (GUARD_W < 1) $error("GUARD_W must be at least 1");
   end

   logic guard_unused;
   if (GUARD_W > 1) begin : g_guard_hi
      assign guard_unused = ^req_guard[GUARD_W-1:1];
   end else begin : g_guard_one
      assign guard_unused = 1'b0;
   end

   wstore_pkg::byte_order_e order;
   assign order = little_en ? wstore_pkg::ORDER_LITTLE : wstore_pkg::ORDER_BIG;

   logic accept, misaligned, in_window;
   logic [DATA_W-1:0] lanes_data;

   assign accept     = req_valid && req_guard[0];
   assign misaligned = |req_addr[OFFS_W-1:0];

   wstore_lane_mux #(.DATA_W(DATA_W)) u_lanes (
      .word_in  (req_data),
      .order    (order),
      .word_out (lanes_data)
   );

   wstore_window #(.ADDR_W(ADDR_W)) u_window (
      .addr (req_addr),
      .lo   (io_base),
      .hi   (io_limit),
      .hit  (in_window)
   );

   wstore_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .mis_set  (accept && misaligned),
      .trap_en  (trap_en),
      .flag_clr (status_clr),
      .take_ack (jump_ack),
      .flag_q   (misalign_flag),
      .trap_q   (trap_pending)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_we    <= 1'b0;
         mem_waddr <= '0;
         mem_wdata <= '0;
         mem_be    <= '0;
         io_we     <= 1'b0;
         io_waddr  <= '0;
         io_wdata  <= '0;
      end else begin
         mem_we <= accept && !in_window;
         io_we  <= accept && in_window;
         mem_be <= (accept && !in_window) ? {LANES{1'b1}} : {LANES{1'b0}};
         if (accept && !in_window) begin
            mem_waddr <= req_addr[ADDR_W-1:OFFS_W];
            mem_wdata <= lanes_data;
         end
         if (accept && in_window) begin
            io_waddr <= req_addr[ADDR_W-1:OFFS_W];
            io_wdata <= req_data;
         end
      end
   end

   AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && io_we)); // R10
   AST_GUARD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid || !req_guard[0]) |=> (!mem_we && !io_we)); // R5
   AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_waddr == $past(req_addr[ADDR_W-1:OFFS_W]))); // R2
   AST_IO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      io_we |-> (io_wdata == $past(req_data))); // R10
   AST_FULL_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> $countones(mem_be) == LANES); // R2

endmodule

// File: tb/wstore_unit_test.sv
`timescale 1ns/1ps
module wstore_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_guard = '0, req_addr = '0, req_data = '0;
   logic        little_en = 1'b0, trap_en = 1'b0, status_clr = 1'b0, jump_ack = 1'b0;
   logic [31:0] io_base = 32'h4000_0000, io_limit = 32'h4000_00FF;
   logic        mem_we, io_we, misalign_flag, trap_pending;
   logic [29:0] mem_waddr, io_waddr;
   logic [31:0] mem_wdata, io_wdata;
   logic [3:0]  mem_be;

   always #4 clk = ~clk;

   wstore_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_guard(req_guard),
      .req_addr(req_addr), .req_data(req_data), .little_en(little_en),
      .trap_en(trap_en), .status_clr(status_clr), .jump_ack(jump_ack),
      .io_base(io_base), .io_limit(io_limit), .mem_we(mem_we),
      .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_be(mem_be),
      .io_we(io_we), .io_waddr(io_waddr), .io_wdata(io_wdata),
      .misalign_flag(misalign_flag), .trap_pending(trap_pending)
   );

   int checks = 0;
   int fails  = 0;
   bit started = 0;
   bit done = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference model, updated at every rising edge.
   bit          e_mwe, e_iwe, e_flag, e_trap;
   logic [29:0] e_maddr, e_iaddr;
   logic [31:0] e_mdata, e_idata;
   logic [3:0]  e_be;

   function automatic logic [31:0] arrange(input logic [31:0] d, input bit le);
      if (le) return d;
      return {d[7:0], d[15:8], d[23:16], d[31:24]};
   endfunction

   always @(posedge clk) begin
      started = 1;
      if (!rst_n) begin
         e_mwe = 0; e_iwe = 0; e_flag = 0; e_trap = 0;
         e_maddr = '0; e_iaddr = '0; e_mdata = '0; e_idata = '0; e_be = '0;
      end else begin
         bit go, hit, mis;
         go  = req_valid && req_guard[0];
         hit = (req_addr >= io_base) && (req_addr <= io_limit);
         mis = (req_addr % 4) != 0;
         e_mwe = go && !hit;
         e_iwe = go && hit;
         e_be  = e_mwe ? 4'hF : 4'h0;
         if (e_mwe) begin e_maddr = req_addr / 4; e_mdata = arrange(req_data, little_en); end
         if (e_iwe) begin e_iaddr = req_addr / 4; e_idata = req_data; end
         if (go && mis) e_flag = 1;
         else if (status_clr) e_flag = 0;
         if (go && mis && trap_en) e_trap = 1;
         else if (jump_ack) e_trap = 0;
      end
   end

   always @(negedge clk) begin
      if (started && !done) begin
         check(mem_we == e_mwe, "R2 mem_we", 32'(mem_we), 32'(e_mwe));
         check(mem_be == e_be, "R2 mem_be", 32'(mem_be), 32'(e_be));
         check(mem_waddr == e_maddr, "R2 mem_waddr", 32'(mem_waddr), 32'(e_maddr));
         check(mem_wdata == e_mdata, "R3/R4 mem_wdata", mem_wdata, e_mdata);
         check(io_we == e_iwe, "R10 io_we", 32'(io_we), 32'(e_iwe));
         check(io_waddr == e_iaddr, "R10 io_waddr", 32'(io_waddr), 32'(e_iaddr));
         check(io_wdata == e_idata, "R10 io_wdata", io_wdata, e_idata);
         check(misalign_flag == e_flag, "R6/R7 misalign_flag", 32'(misalign_flag), 32'(e_flag));
         check(trap_pending == e_trap, "R8/R9 trap_pending", 32'(trap_pending), 32'(e_trap));
      end
   end

   // Drives one cycle of inputs at a falling edge, returns at the next one.
   task automatic put(input bit v, input logic [31:0] g, input logic [31:0] a, input logic [31:0] d,
                      input bit le, input bit te, input bit clr, input bit ack);
      req_valid = v; req_guard = g; req_addr = a; req_data = d;
      little_en = le; trap_en = te; status_clr = clr; jump_ack = ack;
      @(negedge clk);
   endtask

   task automatic idle();
      put(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!mem_we && !io_we && mem_be == 0, "R1 strobes in reset", {mem_we, io_we, 26'b0, mem_be}, 0);
      check(!misalign_flag && !trap_pending, "R1 status in reset", {misalign_flag, trap_pending}, 0);
      rst_n = 1'b1;
      idle();
      check(mem_wdata == 0 && io_wdata == 0, "R1 data after reset", mem_wdata | io_wdata, 0);

      // R3: big-endian example
      put(1, 1, 32'h0000_0D00, 32'h4433_2211, 0, 0, 0, 0);
      check(mem_wdata == 32'h1122_3344, "R3 big-endian lanes", mem_wdata, 32'h1122_3344);
      check(mem_waddr == 30'h340, "R2 word address", 32'(mem_waddr), 32'h340);
      check(mem_be == 4'hF, "R2 byte enables", 32'(mem_be), 32'hF);
      // R4: little-endian
      put(1, 1, 32'h0000_0D00, 32'h4433_2211, 1, 0, 0, 0);
      check(mem_wdata == 32'h4433_2211, "R4 little-endian lanes", mem_wdata, 32'h4433_2211);
      // R5: guard bit 0 clear, upper bits set, misaligned, trap enabled
      put(1, 32'hFFFF_FFFE, 32'h0000_0D01, 32'hAABB_CCDD, 0, 1, 0, 0);
      check(!mem_we && !io_we, "R5 no write on false guard", {mem_we, io_we}, 0);
      check(!misalign_flag && !trap_pending, "R5 no status on false guard", {misalign_flag, trap_pending}, 0);
      put(1, 1, 32'h0000_0D04, 32'hAABB_CCDD, 0, 0, 0, 0);
      check(mem_wdata == 32'hDDCC_BBAA, "R3 second big-endian word", mem_wdata, 32'hDDCC_BBAA);
      idle();
      check(!mem_we, "R2 single-cycle strobe", 32'(mem_we), 0);

      // R6/R8: misaligned, trap off
      put(1, 1, 32'h0000_0D06, 32'h0102_0304, 0, 0, 0, 0);
      check(mem_we && mem_waddr == 30'h341, "R6 misaligned write address", 32'(mem_waddr), 32'h341);
      check(misalign_flag, "R6 flag set", 32'(misalign_flag), 1);
      check(!trap_pending, "R8 no trap when disabled", 32'(trap_pending), 0);
      repeat (3) idle();
      check(misalign_flag, "R7 flag sticky", 32'(misalign_flag), 1);
      put(1, 1, 32'h0000_0D03, 32'h0, 0, 0, 1, 0);
      check(misalign_flag, "R7 set beats clear", 32'(misalign_flag), 1);
      put(0, 0, 0, 0, 0, 0, 1, 0);
      check(!misalign_flag, "R7 flag cleared", 32'(misalign_flag), 0);

      // R8/R9: trap
      put(1, 1, 32'h0000_0E02, 32'h0, 1, 1, 0, 0);
      check(trap_pending, "R8 trap raised", 32'(trap_pending), 1);
      repeat (2) idle();
      check(trap_pending, "R9 trap held", 32'(trap_pending), 1);
      put(1, 1, 32'h0000_0E01, 32'h0, 1, 1, 0, 1);
      check(trap_pending, "R9 new trap beats ack", 32'(trap_pending), 1);
      put(0, 0, 0, 0, 0, 0, 0, 1);
      check(!trap_pending, "R9 trap taken", 32'(trap_pending), 0);

      // R10: I/O window, both byte orders and both bounds
      put(1, 1, 32'h4000_0000, 32'h1234_5678, 0, 0, 0, 0);
      check(io_we && !mem_we, "R10 base routes to io", {io_we, mem_we}, 32'b10);
      check(io_wdata == 32'h1234_5678, "R10 big-endian unswapped", io_wdata, 32'h1234_5678);
      put(1, 1, 32'h4000_00FF, 32'h8765_4321, 1, 0, 0, 0);
      check(io_we && io_wdata == 32'h8765_4321, "R10 limit inclusive", io_wdata, 32'h8765_4321);
      put(1, 1, 32'h4000_0100, 32'h1234_5678, 0, 0, 0, 0);
      check(mem_we && !io_we, "R10 above limit goes to memory", {io_we, mem_we}, 32'b01);
      put(0, 0, 0, 0, 0, 0, 1, 1);

      // Random phase, compared every cycle by the model
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] a;
         case ($urandom % 4)
            0: a = 32'h4000_0000 + ($urandom % 32'h140);
            1: a = 32'h3FFF_FFF0 + ($urandom % 32'h20);
            default: a = $urandom;
         endcase
         put(($urandom % 4) != 0, $urandom, a, $urandom, $urandom % 2,
             $urandom % 2, ($urandom % 6) == 0, ($urandom % 5) == 0);
      end
      idle();

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule